// File: doc/BRIEF.md
# Speculative In-Order Completion Queue

This block is a ring of in-flight instruction records kept in program order. Each record holds a result tag, a rename-register index, a finished flag, a speculation flag and the identifier of the branch that guards it. Instructions leave the ring from the oldest end, and only in order, when the block writes them back to architected state. An instruction issued behind a predicted branch that is still open may finish executing, but its record stays in the ring and does not write back until that branch is settled.

The branch unit reports the outcome of a prediction in one of two ways. A correct-prediction pulse names a branch identifier. Every record guarded by that identifier drops its speculation flag in the same cycle, so it can retire from the next cycle on. A misprediction names the ring position of the branch. Every record younger than that position is removed in that cycle: the tail moves back to the slot just after the branch, and the removed slots and their rename indices are shown on a squash output so the rename logic can free them. Execution, rename allocation and prediction are outside the block and reach it only as inputs.

Top module: `cq_spec_queue`

## Requirements
- R1: After reset the ring is empty. `ret_valid` and `sq_mask` are zero, `disp_ptr` is zero, and a two-lane dispatch request is accepted.
- R2: Dispatch lanes are packed from lane 0 upward. A request for N lanes is accepted only when at least N slots are free, counting occupancy at the start of the cycle. When it is accepted, lane k is written to ring position `disp_ptr`+k, and `disp_ptr` advances by N.
- R3: When all 8 slots are occupied, `disp_accept` is low for any non-empty request, even when a completion arrives in the same cycle, and nothing is written.
- R4: Retirement happens only from the oldest slot, in order, up to 2 per cycle. Lane k of `ret_valid` is set only when lane k-1 is set and slot head+k holds a finished, non-speculative record. A finished record behind an unfinished one does not retire.
- R5: A finished record still marked speculative does not retire, however many cycles pass.
- R6: A correct-prediction pulse clears the speculation flag of every record guarded by the named identifier. Those records can retire from the next cycle on. Records guarded by other identifiers keep their flag.
- R7: On a misprediction at ring pointer P, `sq_mask` marks every occupied slot younger than P in that same cycle, and `sq_ren` shows their rename indices. The next dispatch pointer becomes P+1. Squashed records never retire.
- R8: A retirement of records older than the mispredicted branch still takes place in the misprediction cycle.
- R9: In a misprediction cycle `disp_accept` is low and no dispatch is written.
- R10: A completion pulse with a slot index sets that slot's finished flag. This flag is one of the two conditions for retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_req | input | DISP_LANES | Dispatch lane requests, packed from lane 0 |
| disp_spec | input | DISP_LANES | Per lane: record is guarded by an open branch |
| disp_br | input | DISP_LANES*BR_W | Per lane: guarding branch identifier |
| disp_tag | input | DISP_LANES*TAG_W | Per lane: result tag |
| disp_ren | input | DISP_LANES*REN_W | Per lane: rename-register index |
| disp_accept | output | 1 | All requested lanes are written this cycle |
| disp_ptr | output | IDX_W+1 | Ring pointer (with wrap bit) for lane 0 |
| cmpl_valid | input | CMPL_LANES | Completion pulses |
| cmpl_idx | input | CMPL_LANES*IDX_W | Slot index per completion |
| res_valid | input | 1 | Correct-prediction pulse |
| res_br | input | BR_W | Identifier of the correctly predicted branch |
| flush_valid | input | 1 | Misprediction pulse |
| flush_ptr | input | IDX_W+1 | Ring pointer of the mispredicted branch |
| ret_valid | output | RET_LANES | Retiring lanes this cycle |
| ret_tag | output | RET_LANES*TAG_W | Tags of retiring records |
| ret_ren | output | RET_LANES*REN_W | Rename indices of retiring records |
| sq_mask | output | DEPTH | Slots removed by the current misprediction |
| sq_ren | output | DEPTH*REN_W | Rename index held by each slot |

## Verification
Retirement is driven with three completion orders: oldest-first, a younger record finishing before the oldest, and completions that fill a speculative run. These separate true in-order gating from gating on the finished flag alone. Speculation is resolved by two identifiers in turn, which shows that only matching records are released, and only one cycle after the pulse. Admission is tried at 0, 1 and 2 free slots and with a completion in the same cycle, which isolates the free-slot test from other traffic. A misprediction is applied while an older record retires and a dispatch is requested. This shows that the squash mask, the pointer rollback, the retirement of the older record and the dispatch block all act in one cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;
   localparam int CQ_DEPTH_DEF = 8;
   localparam int CQ_LANES_DEF = 2;

   typedef struct packed {
      logic done;
      logic spec;
   } cq_flags_t;
endpackage

// File: rtl/cq_alloc.sv
module cq_alloc #(
   parameter int DEPTH      = 8,
   parameter int DISP_LANES = 2,
   parameter int PTR_W      = 4
) (
   input  logic [PTR_W-1:0]      occ,
   input  logic [DISP_LANES-1:0] disp_req,
   input  logic                  flush_valid,
   output logic                  accept,
   output logic [PTR_W-1:0]      need
);
   logic [PTR_W-1:0] free_slots;

   always_comb begin
      need = '0;
      for (int k = 0; k < DISP_LANES; k++)
         if (disp_req[k]) need = need + PTR_W'(1);
   end

   assign free_slots = PTR_W'(DEPTH) - occ;
   assign accept     = !flush_valid && (need <= free_slots);
endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel #(
   parameter int DEPTH     = 8,
   parameter int RET_LANES = 2,
   parameter int IDX_W     = 3,
   parameter int PTR_W     = 4
) (
   input  logic [IDX_W-1:0]           head_idx,
   input  logic [PTR_W-1:0]           occ,
   input  logic [DEPTH-1:0]           done_vec,
   input  logic [DEPTH-1:0]           spec_vec,
   output logic [RET_LANES-1:0]       ret_valid,
   output logic [RET_LANES*IDX_W-1:0] ret_idx,
   output logic [PTR_W-1:0]           ret_cnt
);
   always_comb begin
      logic chain;
      logic [IDX_W-1:0] slot;
      chain   = 1'b1;
      ret_cnt = '0;
      for (int k = 0; k < RET_LANES; k++) begin
         slot = head_idx + IDX_W'(k);
         ret_idx[k*IDX_W +: IDX_W] = slot;
         ret_valid[k] = chain && (PTR_W'(k) < occ) && done_vec[slot] && !spec_vec[slot];
         chain = ret_valid[k];
         if (ret_valid[k]) ret_cnt = ret_cnt + PTR_W'(1);
      end
   end
endmodule

// File: rtl/cq_squash_mask.sv
module cq_squash_mask #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3,
   parameter int PTR_W = 4
) (
   input  logic [IDX_W-1:0] head_idx,
   input  logic [PTR_W-1:0] occ,
   input  logic             flush_valid,
   input  logic [IDX_W-1:0] flush_idx,
   output logic [DEPTH-1:0] mask
);
   logic [IDX_W-1:0] br_off;
   assign br_off = flush_idx - head_idx;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [IDX_W-1:0] off;
      logic             live;
      assign off     = IDX_W'(i) - head_idx;
      assign live    = {1'b0, off} < occ;
      assign mask[i] = flush_valid && live && (off > br_off);
   end
endmodule

// File: rtl/cq_spec_queue.sv
module cq_spec_queue #(
   parameter int DEPTH      = cq_pkg::CQ_DEPTH_DEF,
   parameter int TAG_W      = 6,
   parameter int REN_W      = 5,
   parameter int BR_W       = 2,
   parameter int DISP_LANES = cq_pkg::CQ_LANES_DEF,
   parameter int RET_LANES  = cq_pkg::CQ_LANES_DEF,
   parameter int CMPL_LANES = 2,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int PTR_W     = IDX_W + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DISP_LANES-1:0]       disp_req,
   input  logic [DISP_LANES-1:0]       disp_spec,
   input  logic [DISP_LANES*BR_W-1:0]  disp_br,
   input  logic [DISP_LANES*TAG_W-1:0] disp_tag,
   input  logic [DISP_LANES*REN_W-1:0] disp_ren,
   output logic                        disp_accept,
   output logic [PTR_W-1:0]            disp_ptr,
   input  logic [CMPL_LANES-1:0]       cmpl_valid,
   input  logic [CMPL_LANES*IDX_W-1:0] cmpl_idx,
   input  logic                        res_valid,
   input  logic [BR_W-1:0]             res_br,
   input  logic                        flush_valid,
   input  logic [PTR_W-1:0]            flush_ptr,
   output logic [RET_LANES-1:0]        ret_valid,
   output logic [RET_LANES*TAG_W-1:0]  ret_tag,
   output logic [RET_LANES*REN_W-1:0]  ret_ren,
   output logic [DEPTH-1:0]            sq_mask,
   output logic [DEPTH*REN_W-1:0]      sq_ren
);
   import cq_pkg::*;

   localparam int LANE_W = (DISP_LANES > 1) ? $clog2(DISP_LANES) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cq_spec_queue: DEPTH must be a power of two of at least 2");
   end
   if (DISP_LANES < 1 || DISP_LANES > DEPTH) begin : g_bad_disp
      $error("cq_spec_queue: DISP_LANES out of range");
   end
   if (RET_LANES < 1 || RET_LANES > DEPTH) begin : g_bad_ret
      $error("cq_spec_queue: RET_LANES out of range");
   end

   logic [PTR_W-1:0] head_q, tail_q, occ, need, ret_cnt;
   cq_flags_t        flags_q [DEPTH];
   logic [TAG_W-1:0] tag_q   [DEPTH];
   logic [REN_W-1:0] ren_q   [DEPTH];
   logic [BR_W-1:0]  br_q    [DEPTH];
   logic [DEPTH-1:0] done_vec, spec_vec, wr_hit, cm_hit;
   logic [LANE_W-1:0] wr_lane [DEPTH];
   logic [RET_LANES*IDX_W-1:0] ret_idx;
   logic             do_disp;

   assign occ      = tail_q - head_q;
   assign disp_ptr = tail_q;
   assign do_disp  = disp_accept && (|disp_req);

   cq_alloc #(.DEPTH(DEPTH), .DISP_LANES(DISP_LANES), .PTR_W(PTR_W)) u_alloc (
      .occ(occ), .disp_req(disp_req), .flush_valid(flush_valid),
      .accept(disp_accept), .need(need)
   );

   cq_retire_sel #(.DEPTH(DEPTH), .RET_LANES(RET_LANES), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_ret (
      .head_idx(head_q[IDX_W-1:0]), .occ(occ), .done_vec(done_vec), .spec_vec(spec_vec),
      .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_cnt(ret_cnt)
   );

   cq_squash_mask #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_sq (
      .head_idx(head_q[IDX_W-1:0]), .occ(occ), .flush_valid(flush_valid),
      .flush_idx(flush_ptr[IDX_W-1:0]), .mask(sq_mask)
   );

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         wr_hit[i]  = 1'b0;
         wr_lane[i] = '0;
         cm_hit[i]  = 1'b0;
         for (int k = 0; k < DISP_LANES; k++) begin
            if (do_disp && disp_req[k] &&
                (IDX_W'(tail_q[IDX_W-1:0] + IDX_W'(k)) == IDX_W'(i))) begin
               wr_hit[i]  = 1'b1;
               wr_lane[i] = LANE_W'(k);
            end
         end
         for (int c = 0; c < CMPL_LANES; c++)
            if (cmpl_valid[c] && cmpl_idx[c*IDX_W +: IDX_W] == IDX_W'(i))
               cm_hit[i] = 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign done_vec[i] = flags_q[i].done;
      assign spec_vec[i] = flags_q[i].spec;
      assign sq_ren[i*REN_W +: REN_W] = ren_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags_q[i] <= '0;
            tag_q[i]   <= '0;
            ren_q[i]   <= '0;
            br_q[i]    <= '0;
         end else if (wr_hit[i]) begin
            flags_q[i].done <= 1'b0;
            flags_q[i].spec <= disp_spec[wr_lane[i]];
            tag_q[i]        <= disp_tag[wr_lane[i]*TAG_W +: TAG_W];
            ren_q[i]        <= disp_ren[wr_lane[i]*REN_W +: REN_W];
            br_q[i]         <= disp_br[wr_lane[i]*BR_W +: BR_W];
         end else begin
            if (cm_hit[i]) flags_q[i].done <= 1'b1;
            if (res_valid && flags_q[i].spec && br_q[i] == res_br)
               flags_q[i].spec <= 1'b0;
         end
      end
   end

   for (genvar k = 0; k < RET_LANES; k++) begin : g_rport
      assign ret_tag[k*TAG_W +: TAG_W] = tag_q[ret_idx[k*IDX_W +: IDX_W]];
      assign ret_ren[k*REN_W +: REN_W] = ren_q[ret_idx[k*IDX_W +: IDX_W]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + ret_cnt;
         if (flush_valid)  tail_q <= flush_ptr + PTR_W'(1);
         else if (do_disp) tail_q <= tail_q + need;
      end
   end
endmodule

// File: rtl/cq_spec_queue_chk.sv
module cq_spec_queue_chk #(
   parameter int DEPTH      = 8,
   parameter int DISP_LANES = 2,
   parameter int RET_LANES  = 2,
   parameter int IDX_W      = 3,
   parameter int PTR_W      = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [DISP_LANES-1:0] disp_req,
   input logic                  disp_accept,
   input logic                  flush_valid,
   input logic [PTR_W-1:0]      flush_ptr,
   input logic [RET_LANES-1:0]  ret_valid,
   input logic [PTR_W-1:0]      head_q,
   input logic [PTR_W-1:0]      tail_q,
   input logic [DEPTH-1:0]      spec_vec
);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q - head_q) <= PTR_W'(DEPTH));

   a_r4_lanes_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      ((ret_valid + RET_LANES'(1)) & ret_valid) == '0);

   a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> head_q == $past(head_q) + PTR_W'($countones($past(ret_valid))));

   a_r5_head_not_spec: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[0] |-> !spec_vec[head_q[IDX_W-1:0]]);

   a_r2_tail_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_valid && disp_accept) |=>
         tail_q == $past(tail_q) + PTR_W'($countones($past(disp_req))));

   a_r7_tail_rollback: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> tail_q == $past(flush_ptr) + PTR_W'(1));

   a_r9_no_dispatch_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> !disp_accept);
endmodule

bind cq_spec_queue cq_spec_queue_chk #(
   .DEPTH(DEPTH), .DISP_LANES(DISP_LANES), .RET_LANES(RET_LANES),
   .IDX_W(IDX_W), .PTR_W(PTR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .disp_accept(disp_accept),
   .flush_valid(flush_valid), .flush_ptr(flush_ptr), .ret_valid(ret_valid),
   .head_q(head_q), .tail_q(tail_q), .spec_vec(spec_vec)
);

// File: tb/tb_cq_spec_queue.sv
`timescale 1ns/1ps
module tb_cq_spec_queue;
   localparam int DEPTH = 8, TAG_W = 6, REN_W = 5, BR_W = 2, LN = 2, IDX_W = 3, PTR_W = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic [LN-1:0]       disp_req, disp_spec;
   logic [LN*BR_W-1:0]  disp_br;
   logic [LN*TAG_W-1:0] disp_tag;
   logic [LN*REN_W-1:0] disp_ren;
   logic                disp_accept;
   logic [PTR_W-1:0]    disp_ptr;
   logic [LN-1:0]       cmpl_valid;
   logic [LN*IDX_W-1:0] cmpl_idx;
   logic                res_valid;
   logic [BR_W-1:0]     res_br;
   logic                flush_valid;
   logic [PTR_W-1:0]    flush_ptr;
   logic [LN-1:0]       ret_valid;
   logic [LN*TAG_W-1:0] ret_tag;
   logic [LN*REN_W-1:0] ret_ren;
   logic [DEPTH-1:0]    sq_mask;
   logic [DEPTH*REN_W-1:0] sq_ren;

   int checks = 0, failures = 0;

   always #10 clk = ~clk;

   cq_spec_queue dut (
      .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .disp_spec(disp_spec),
      .disp_br(disp_br), .disp_tag(disp_tag), .disp_ren(disp_ren),
      .disp_accept(disp_accept), .disp_ptr(disp_ptr), .cmpl_valid(cmpl_valid),
      .cmpl_idx(cmpl_idx), .res_valid(res_valid), .res_br(res_br),
      .flush_valid(flush_valid), .flush_ptr(flush_ptr), .ret_valid(ret_valid),
      .ret_tag(ret_tag), .ret_ren(ret_ren), .sq_mask(sq_mask), .sq_ren(sq_ren)
   );

   function automatic logic [REN_W-1:0] ren_of(input logic [TAG_W-1:0] t);
      return REN_W'(t + 6'd3);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      disp_req = '0; disp_spec = '0; disp_br = '0; disp_tag = '0; disp_ren = '0;
      cmpl_valid = '0; cmpl_idx = '0; res_valid = 1'b0; res_br = '0;
      flush_valid = 1'b0; flush_ptr = '0;
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
      idle();
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; idle();
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst_n = 1'b1; #1;
   endtask

   task automatic set_lane(input int k, input logic [TAG_W-1:0] t,
                           input logic s, input logic [BR_W-1:0] b);
      disp_req[k] = 1'b1; disp_spec[k] = s;
      disp_tag[k*TAG_W +: TAG_W] = t;
      disp_ren[k*REN_W +: REN_W] = ren_of(t);
      disp_br[k*BR_W +: BR_W] = b;
   endtask

   task automatic cmpl(input logic [IDX_W-1:0] a, input logic va,
                       input logic [IDX_W-1:0] b, input logic vb);
      cmpl_valid = {vb, va}; cmpl_idx = {b, a};
      step();
   endtask

   task automatic check_ret(input string req, input logic [LN-1:0] v,
                            input logic [TAG_W-1:0] t0, input logic [TAG_W-1:0] t1);
      check(req, "ret_valid", 64'(ret_valid), 64'(v));
      if (v[0]) begin
         check(req, "ret_tag0", 64'(ret_tag[TAG_W-1:0]), 64'(t0));
         check(req, "ret_ren0", 64'(ret_ren[REN_W-1:0]), 64'(ren_of(t0)));
      end
      if (v[1]) check(req, "ret_tag1", 64'(ret_tag[2*TAG_W-1:TAG_W]), 64'(t1));
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "disp_ptr", 64'(disp_ptr), 0);
      check("R1", "ret_valid", 64'(ret_valid), 0);
      check("R1", "sq_mask", 64'(sq_mask), 0);
      disp_req = 2'b11; #1;
      check("R1", "accept two", 64'(disp_accept), 1);
      disp_req = '0; #1;
   endtask

   task automatic t_order();
      do_reset();
      set_lane(0, 6'd1, 0, 0); set_lane(1, 6'd2, 0, 0); step();
      set_lane(0, 6'd3, 0, 0); step();
      check("R2", "disp_ptr", 64'(disp_ptr), 3);
      check_ret("R4", 2'b00, 0, 0);
      cmpl(3'd1, 1, 3'd0, 0);
      check_ret("R4 younger done only", 2'b00, 0, 0);
      cmpl(3'd0, 1, 3'd0, 0);
      check_ret("R10", 2'b11, 6'd1, 6'd2);
      step();
      check_ret("R4 third not done", 2'b00, 0, 0);
      cmpl(3'd2, 1, 3'd0, 0);
      check_ret("R4", 2'b01, 6'd3, 0);
      step();
      check_ret("R4 drained", 2'b00, 0, 0);
   endtask

   task automatic t_full();
      do_reset();
      for (int c = 0; c < 4; c++) begin
         set_lane(0, 6'(2*c+1), 0, 0); set_lane(1, 6'(2*c+2), 0, 0); step();
      end
      check("R2", "disp_ptr full", 64'(disp_ptr), 8);
      disp_req = 2'b01; cmpl_valid = 2'b01; cmpl_idx = '0; #1;
      check("R3", "accept when full", 64'(disp_accept), 0);
      step();
      check_ret("R4", 2'b01, 6'd1, 0);
      step();
      disp_req = 2'b11; #1;
      check("R2", "two with one free", 64'(disp_accept), 0);
      disp_req = 2'b01; #1;
      check("R2", "one with one free", 64'(disp_accept), 1);
      idle();
      set_lane(0, 6'd9, 0, 0); step();
      check("R2", "disp_ptr wrap", 64'(disp_ptr), 9);
      disp_req = 2'b01; #1;
      check("R3", "accept full again", 64'(disp_accept), 0);
      idle(); #1;
   endtask

   task automatic t_spec();
      do_reset();
      set_lane(0, 6'd10, 0, 0); set_lane(1, 6'd11, 1, 2'd1); step();
      set_lane(0, 6'd12, 1, 2'd1); set_lane(1, 6'd13, 1, 2'd2); step();
      cmpl(3'd2, 1, 3'd3, 1);
      cmpl(3'd0, 1, 3'd1, 1);
      check_ret("R5", 2'b01, 6'd10, 0);
      step();
      check_ret("R5", 2'b00, 0, 0);
      step();
      check_ret("R5 still held", 2'b00, 0, 0);
      res_valid = 1'b1; res_br = 2'd1; #1;
      check_ret("R6 same cycle", 2'b00, 0, 0);
      step();
      check_ret("R6", 2'b11, 6'd11, 6'd12);
      step();
      check_ret("R6 other id", 2'b00, 0, 0);
      res_valid = 1'b1; res_br = 2'd2; step();
      check_ret("R6", 2'b01, 6'd13, 0);
      step();
   endtask

   task automatic t_flush();
      do_reset();
      set_lane(0, 6'd20, 0, 0); set_lane(1, 6'd21, 0, 0); step();
      set_lane(0, 6'd22, 1, 0); set_lane(1, 6'd23, 1, 0); step();
      set_lane(0, 6'd24, 1, 0); step();
      cmpl(3'd2, 1, 3'd3, 1);
      cmpl(3'd0, 1, 3'd0, 0);
      flush_valid = 1'b1; flush_ptr = 4'd1;
      set_lane(0, 6'd30, 0, 0); #1;
      check("R9", "accept on flush", 64'(disp_accept), 0);
      check("R7", "sq_mask", 64'(sq_mask), 64'h1C);
      check("R7", "sq_ren slot2", 64'(sq_ren[2*REN_W +: REN_W]), 64'(ren_of(6'd22)));
      check_ret("R8", 2'b01, 6'd20, 0);
      step();
      check("R7", "disp_ptr rollback", 64'(disp_ptr), 2);
      check("R7", "sq_mask after", 64'(sq_mask), 0);
      cmpl(3'd1, 1, 3'd0, 0);
      check_ret("R7 squashed no retire", 2'b01, 6'd21, 0);
      step();
      check_ret("R7", 2'b00, 0, 0);
      set_lane(0, 6'd31, 0, 0); step();
      check_ret("R7 reused slot", 2'b00, 0, 0);
      cmpl(3'd2, 1, 3'd0, 0);
      check_ret("R10", 2'b01, 6'd31, 0);
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; idle();
      @(negedge clk);
      t_reset();
      t_order();
      t_full();
      t_spec();
      t_flush();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule